// File: doc/BRIEF.md
# Outstanding Miss Tracker

This block tracks the cache-line misses that are waiting on the next memory level. It holds a small set of entries. Each entry records a line address, an address-space identifier, the owning thread, a list of target commands, an age stamp and the flags that describe the access. A cacheable miss request is compared with every live entry by both line address and address-space identifier. On a hit, the request is appended to that entry as another target. On a miss, the lowest-numbered free entry is claimed. Uncacheable requests always claim an entry of their own and keep their exact address and byte count.

Pending entries are presented one at a time on the issue port. The consumer accepts the presented entry with a take pulse, which moves it to in-service. A fill response names an entry. When the fill serves only the head target and other targets wait behind it, the entry returns to pending with a fresh age stamp and the next target's command. Otherwise the entry is released. A squash frees every entry owned by the named thread.

The block raises two independent blocking causes. One is raised when every entry is in use. The other is raised when an entry's target list has reached its cap. While either cause is up, new requests are refused. The entry that reached its cap jumps ahead of older entries on the issue port.

Top module: `mshr_file`

## Requirements
- R1: The issue port presents a cacheable entry's address with the low log2(LINE_BYTES) bits cleared, and an uncacheable entry's address unchanged.
- R2: A cacheable request whose line address and address-space identifier both equal those of a live cacheable entry merges into it: req_merged=1, req_slot names that entry, and no entry is claimed. A difference in either field claims the lowest free entry.
- R3: An allocating request (req_noalloc=0) that merges into an entry flagged no-allocate clears that entry's flag, which is seen on iss_noalloc.
- R4: When a merge brings an entry's target count to MAX_TGT, blk_tgt rises and req_ready falls. Requests presented while blk_tgt is high are not accepted. While that entry is pending, it is issued ahead of any older entry.
- R5: An uncacheable request never merges and is never merged into. Its entry reports iss_size equal to req_size, while a cacheable entry reports LINE_BYTES.
- R6: Each claim of an entry and each return to pending takes the next value of one shared counter, starting at 0 after reset (iss_order). When no target cap is active, the issue port presents the pending entry with the smallest stamp.
- R7: blk_full is high exactly when every entry is pending or in service. Requests are not accepted while it is high, and it falls in the cycle after an entry is released.
- R8: A fill with fill_partial=1 on an entry that holds more than one target drops the head target and returns the entry to pending, with iss_cmd equal to the second target's command and a fresh stamp. Any other fill releases the entry.
- R9: A fill on the entry that raised blk_tgt clears blk_tgt.
- R10: A squash for a thread frees every entry whose single owner is that thread. It also clears blk_tgt when the entry that raised it is owned by that thread.
- R11: Merging a request from a thread other than the entry's owner sets iss_multi for that entry. An entry marked this way is not freed by any squash.
- R12: A take pulse while iss_valid is high moves the presented entry to in-service, and it is no longer offered on the issue port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Miss request present |
| req_addr | input | ADDR_W | Request byte address |
| req_asid | input | ASID_W | Address-space identifier |
| req_thread | input | THR_W | Requesting thread |
| req_uncache | input | 1 | Uncacheable access |
| req_noalloc | input | 1 | Access does not allocate in the cache |
| req_cmd | input | CMD_W | Command of the request |
| req_size | input | SZ_W | Byte count, used for uncacheable accesses |
| req_ready | output | 1 | Request will be accepted this cycle |
| req_merged | output | 1 | Request matches a live entry |
| req_slot | output | IDX_W | Entry merged into or claimed |
| iss_valid | output | 1 | A pending entry is presented |
| iss_slot | output | IDX_W | Presented entry |
| iss_addr | output | ADDR_W | Address to fetch |
| iss_cmd | output | CMD_W | Command of the head target |
| iss_size | output | SZ_W | Bytes to fetch |
| iss_noalloc | output | 1 | No-allocate flag of the entry |
| iss_owner | output | THR_W | Owning thread |
| iss_multi | output | 1 | Entry shared by several threads |
| iss_order | output | ORD_W | Age stamp of the entry |
| iss_take | input | 1 | Presented entry enters service |
| fill_valid | input | 1 | Fill response present |
| fill_slot | input | IDX_W | Entry the fill belongs to |
| fill_partial | input | 1 | Fill served only the head target |
| sq_valid | input | 1 | Squash request |
| sq_thread | input | THR_W | Thread to squash |
| blk_full | output | 1 | Cause: no free entry |
| blk_tgt | output | 1 | Cause: target list at cap |

## Verification
On every cycle, the assertions check the following. The full cause agrees with the entry states. The target-cap cause always points at a live entry and rises only in response to a request. Target counts stay within their bounds. The presented entry is really pending. A fill on the blocking entry removes the target block. The age ordering, the merge-versus-claim choice across line and address-space differences, the clearing of the no-allocate flag, re-issue after a partial fill, the thread squash rules, and the refusal of requests while blocked all depend on sequences of requests. Only the bench's directed scenarios can show those.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  typedef enum logic [1:0] {
    E_FREE = 2'd0,
    E_PEND = 2'd1,
    E_BUSY = 2'd2
  } est_t;
endpackage

// File: rtl/mshr_match.sv
module mshr_match #(
  parameter int N    = 4,
  parameter int LA_W = 12,
  parameter int AS_W = 4,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                      en,
  input  logic [N-1:0]              live,
  input  logic [N-1:0]              cand,
  input  logic [N-1:0][LA_W-1:0]    lines,
  input  logic [N-1:0][AS_W-1:0]    asids,
  input  logic [LA_W-1:0]           q_line,
  input  logic [AS_W-1:0]           q_asid,
  output logic                      hit,
  output logic [IDX_W-1:0]          hit_idx,
  output logic                      free_ok,
  output logic [IDX_W-1:0]          free_idx
);
  logic [N-1:0] eq;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign eq[i] = en && cand[i] && (lines[i] == q_line) && (asids[i] == q_asid);
  end

  always_comb begin
    hit      = 1'b0;
    hit_idx  = '0;
    free_ok  = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
      if (!live[i]) begin
        free_ok  = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/mshr_pick.sv
module mshr_pick #(
  parameter int N     = 4,
  parameter int ORD_W = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]              pend,
  input  logic [N-1:0][ORD_W-1:0]   ords,
  input  logic                      pri_en,
  input  logic [IDX_W-1:0]          pri_idx,
  output logic                      found,
  output logic [IDX_W-1:0]          idx
);
  logic [ORD_W-1:0] best;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && (!found || ords[i] < best)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        best  = ords[i];
      end
    end
    if (pri_en && pend[pri_idx]) idx = pri_idx;
  end
endmodule

// File: rtl/mshr_file.sv
module mshr_file #(
  parameter int N          = 4,
  parameter int MAX_TGT    = 4,
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 16,
  parameter int ASID_W     = 4,
  parameter int THR_W      = 2,
  parameter int CMD_W      = 2,
  parameter int ORD_W      = 16,
  localparam int IDX_W = $clog2(N),
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int LA_W  = ADDR_W - OFF_W,
  localparam int SZ_W  = $clog2(LINE_BYTES + 1),
  localparam int CNT_W = $clog2(MAX_TGT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ASID_W-1:0] req_asid,
  input  logic [THR_W-1:0]  req_thread,
  input  logic              req_uncache,
  input  logic              req_noalloc,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic [SZ_W-1:0]   req_size,
  output logic              req_ready,
  output logic              req_merged,
  output logic [IDX_W-1:0]  req_slot,
  output logic              iss_valid,
  output logic [IDX_W-1:0]  iss_slot,
  output logic [ADDR_W-1:0] iss_addr,
  output logic [CMD_W-1:0]  iss_cmd,
  output logic [SZ_W-1:0]   iss_size,
  output logic              iss_noalloc,
  output logic [THR_W-1:0]  iss_owner,
  output logic              iss_multi,
  output logic [ORD_W-1:0]  iss_order,
  input  logic              iss_take,
  input  logic              fill_valid,
  input  logic [IDX_W-1:0]  fill_slot,
  input  logic              fill_partial,
  input  logic              sq_valid,
  input  logic [THR_W-1:0]  sq_thread,
  output logic              blk_full,
  output logic              blk_tgt
);
  import mshr_pkg::*;

  est_t                               st_q [N];
  est_t                               st_d [N];
  logic [N-1:0][ADDR_W-1:0]           addr_q, addr_d;
  logic [N-1:0][ASID_W-1:0]           asid_q, asid_d;
  logic [N-1:0][THR_W-1:0]            own_q, own_d;
  logic [N-1:0]                       multi_q, multi_d;
  logic [N-1:0]                       unc_q, unc_d;
  logic [N-1:0]                       noal_q, noal_d;
  logic [N-1:0][SZ_W-1:0]             size_q, size_d;
  logic [N-1:0][CNT_W-1:0]            cnt_q, cnt_d;
  logic [N-1:0][MAX_TGT-1:0][CMD_W-1:0] tcmd_q, tcmd_d;
  logic [N-1:0][ORD_W-1:0]            ord_q, ord_d;
  logic [ORD_W-1:0]                   ctr_q, ctr_d;
  logic                               full_q, full_d;
  logic                               tblk_q, tblk_d;
  logic [IDX_W-1:0]                   tslot_q, tslot_d;

  logic [N-1:0]             live, pend, cand;
  logic [N-1:0][LA_W-1:0]   lines;
  logic                     m_hit, m_free_ok;
  logic [IDX_W-1:0]         m_hit_idx, m_free_idx;
  logic                     req_fire, repend;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      live[i]  = (st_q[i] != E_FREE);
      pend[i]  = (st_q[i] == E_PEND);
      cand[i]  = live[i] && !unc_q[i];
      lines[i] = addr_q[i][ADDR_W-1:OFF_W];
    end
  end

  mshr_match #(.N(N), .LA_W(LA_W), .AS_W(ASID_W)) i_match (
    .en(!req_uncache), .live(live), .cand(cand), .lines(lines), .asids(asid_q),
    .q_line(req_addr[ADDR_W-1:OFF_W]), .q_asid(req_asid),
    .hit(m_hit), .hit_idx(m_hit_idx), .free_ok(m_free_ok), .free_idx(m_free_idx)
  );

  mshr_pick #(.N(N), .ORD_W(ORD_W)) i_pick (
    .pend(pend), .ords(ord_q), .pri_en(tblk_q), .pri_idx(tslot_q),
    .found(iss_valid), .idx(iss_slot)
  );

  assign req_ready  = !full_q && !tblk_q;
  assign req_fire   = req_valid && req_ready && (m_hit || m_free_ok);
  assign req_merged = m_hit;
  assign req_slot   = m_hit ? m_hit_idx : m_free_idx;
  assign repend     = fill_valid && fill_partial && (cnt_q[fill_slot] > CNT_W'(1));

  // next-state
  always_comb begin
    st_d = st_q;   addr_d = addr_q; asid_d = asid_q; own_d = own_q;
    multi_d = multi_q; unc_d = unc_q; noal_d = noal_q; size_d = size_q;
    cnt_d = cnt_q; tcmd_d = tcmd_q; ord_d = ord_q;
    tblk_d = tblk_q; tslot_d = tslot_q;
    ctr_d  = ctr_q + ORD_W'(repend) + ORD_W'(req_fire && !m_hit);

    if (iss_take && iss_valid) st_d[iss_slot] = E_BUSY;

    if (fill_valid) begin
      if (tblk_q && fill_slot == tslot_q) tblk_d = 1'b0;
      if (repend) begin
        for (int t = 0; t < MAX_TGT - 1; t++) tcmd_d[fill_slot][t] = tcmd_q[fill_slot][t+1];
        cnt_d[fill_slot] = cnt_q[fill_slot] - CNT_W'(1);
        st_d[fill_slot]  = E_PEND;
        ord_d[fill_slot] = ctr_q;
      end else begin
        st_d[fill_slot] = E_FREE;
      end
    end

    if (req_fire) begin
      if (m_hit) begin
        for (int t = 0; t < MAX_TGT; t++)
          if (CNT_W'(t) == cnt_q[m_hit_idx]) tcmd_d[m_hit_idx][t] = req_cmd;
        cnt_d[m_hit_idx] = cnt_q[m_hit_idx] + CNT_W'(1);
        if (own_q[m_hit_idx] != req_thread) multi_d[m_hit_idx] = 1'b1;
        if (!req_noalloc) noal_d[m_hit_idx] = 1'b0;
        if (cnt_q[m_hit_idx] + CNT_W'(1) == CNT_W'(MAX_TGT)) begin
          tblk_d  = 1'b1;
          tslot_d = m_hit_idx;
        end
      end else begin
        st_d[m_free_idx]    = E_PEND;
        addr_d[m_free_idx]  = req_addr;
        asid_d[m_free_idx]  = req_asid;
        own_d[m_free_idx]   = req_thread;
        multi_d[m_free_idx] = 1'b0;
        unc_d[m_free_idx]   = req_uncache;
        noal_d[m_free_idx]  = req_noalloc;
        size_d[m_free_idx]  = req_uncache ? req_size : SZ_W'(LINE_BYTES);
        cnt_d[m_free_idx]   = CNT_W'(1);
        tcmd_d[m_free_idx][0] = req_cmd;
        ord_d[m_free_idx]   = ctr_q + ORD_W'(repend);
      end
    end

    if (sq_valid) begin
      for (int i = 0; i < N; i++)
        if (st_q[i] != E_FREE && !multi_q[i] && own_q[i] == sq_thread) st_d[i] = E_FREE;
      if (tblk_q && !multi_q[tslot_q] && own_q[tslot_q] == sq_thread) tblk_d = 1'b0;
    end

    full_d = 1'b1;
    for (int i = 0; i < N; i++) if (st_d[i] == E_FREE) full_d = 1'b0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) st_q[i] <= E_FREE;
      addr_q <= '0; asid_q <= '0; own_q <= '0; multi_q <= '0; unc_q <= '0;
      noal_q <= '0; size_q <= '0; cnt_q <= '0; tcmd_q <= '0; ord_q <= '0;
      ctr_q <= '0; full_q <= 1'b0; tblk_q <= 1'b0; tslot_q <= '0;
    end else begin
      st_d_copy: for (int i = 0; i < N; i++) st_q[i] <= st_d[i];
      addr_q <= addr_d; asid_q <= asid_d; own_q <= own_d; multi_q <= multi_d;
      unc_q <= unc_d; noal_q <= noal_d; size_q <= size_d; cnt_q <= cnt_d;
      tcmd_q <= tcmd_d; ord_q <= ord_d; ctr_q <= ctr_d;
      full_q <= full_d; tblk_q <= tblk_d; tslot_q <= tslot_d;
    end
  end

  assign blk_full    = full_q;
  assign blk_tgt     = tblk_q;
  assign iss_addr    = unc_q[iss_slot] ? addr_q[iss_slot]
                                       : {addr_q[iss_slot][ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign iss_cmd     = tcmd_q[iss_slot][0];
  assign iss_size    = size_q[iss_slot];
  assign iss_noalloc = noal_q[iss_slot];
  assign iss_owner   = own_q[iss_slot];
  assign iss_multi   = multi_q[iss_slot];
  assign iss_order   = ord_q[iss_slot];

  // checks
  p_full_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    blk_full == (&live));
  p_tgt_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    blk_tgt |-> live[tslot_q]);
  p_tgt_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk_tgt) |-> $past(req_valid));
  p_fill_unblock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_tgt && fill_valid && fill_slot == tslot_q && !req_valid) |=> !blk_tgt);
  p_issue_pend_r12: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (st_q[iss_slot] == E_PEND));
  for (genvar i = 0; i < N; i++) begin : g_chk
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      live[i] |-> (cnt_q[i] >= CNT_W'(1) && cnt_q[i] <= CNT_W'(MAX_TGT)));
  end
endmodule

// File: tb/test_mshr_file.sv
`timescale 1ns/1ps
module test_mshr_file;
  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_uncache, req_noalloc, iss_take, fill_valid, fill_partial, sq_valid;
  logic [15:0] req_addr;
  logic [3:0]  req_asid;
  logic [1:0]  req_thread, req_cmd, sq_thread, fill_slot;
  logic [4:0]  req_size;
  logic        req_ready, req_merged, iss_valid, iss_noalloc, iss_multi, blk_full, blk_tgt;
  logic [1:0]  req_slot, iss_slot, iss_cmd, iss_owner;
  logic [15:0] iss_addr, iss_order;
  logic [4:0]  iss_size;
  int n_chk = 0, n_bad = 0;
  logic cap_merged, cap_ready;
  logic [1:0] cap_slot;

  always #4 clk = ~clk;

  mshr_file i_mshr_file (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_asid(req_asid), .req_thread(req_thread), .req_uncache(req_uncache),
    .req_noalloc(req_noalloc), .req_cmd(req_cmd), .req_size(req_size),
    .req_ready(req_ready), .req_merged(req_merged), .req_slot(req_slot),
    .iss_valid(iss_valid), .iss_slot(iss_slot), .iss_addr(iss_addr), .iss_cmd(iss_cmd),
    .iss_size(iss_size), .iss_noalloc(iss_noalloc), .iss_owner(iss_owner),
    .iss_multi(iss_multi), .iss_order(iss_order), .iss_take(iss_take),
    .fill_valid(fill_valid), .fill_slot(fill_slot), .fill_partial(fill_partial),
    .sq_valid(sq_valid), .sq_thread(sq_thread), .blk_full(blk_full), .blk_tgt(blk_tgt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reset_dut();
    rst_n = 1'b0; req_valid = 0; req_addr = 0; req_asid = 0; req_thread = 0;
    req_uncache = 0; req_noalloc = 0; req_cmd = 0; req_size = 0; iss_take = 0;
    fill_valid = 0; fill_slot = 0; fill_partial = 0; sq_valid = 0; sq_thread = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic req(input logic [15:0] a, input logic [3:0] as, input logic [1:0] th,
                     input logic u, input logic na, input logic [1:0] c, input logic [4:0] sz);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_asid = as; req_thread = th;
    req_uncache = u; req_noalloc = na; req_cmd = c; req_size = sz;
    #1 cap_merged = req_merged; cap_slot = req_slot; cap_ready = req_ready;
    @(posedge clk); #1 req_valid = 0;
  endtask

  task automatic take();
    @(negedge clk); iss_take = 1; @(posedge clk); #1 iss_take = 0;
  endtask

  task automatic fill(input logic [1:0] s, input logic p);
    @(negedge clk); fill_valid = 1; fill_slot = s; fill_partial = p;
    @(posedge clk); #1 fill_valid = 0; fill_partial = 0;
  endtask

  task automatic squash(input logic [1:0] th);
    @(negedge clk); sq_valid = 1; sq_thread = th; @(posedge clk); #1 sq_valid = 0;
  endtask

  task automatic t_reset();
    reset_dut(); #1;
    chk("R7 reset blk_full", blk_full, 0);
    chk("R4 reset blk_tgt", blk_tgt, 0);
    chk("R12 reset iss_valid", iss_valid, 0);
    chk("R7 reset req_ready", req_ready, 1);
  endtask

  task automatic t_addr_size();
    reset_dut();
    req(16'h1234, 1, 0, 0, 0, 1, 4);
    chk("R1 line addr", iss_addr, 16'h1230);
    chk("R5 cacheable size", iss_size, 16);
    chk("R6 first stamp", iss_order, 0);
    req(16'h1238, 1, 0, 1, 0, 2, 4);
    chk("R5 uncache no merge", cap_merged, 0);
    chk("R5 uncache slot", cap_slot, 1);
    chk("R6 oldest first", iss_slot, 0);
    take();
    chk("R12 taken not offered", iss_slot, 1);
    chk("R1 uncache exact addr", iss_addr, 16'h1238);
    chk("R5 uncache size", iss_size, 4);
    chk("R6 second stamp", iss_order, 1);
  endtask

  task automatic t_merge();
    reset_dut();
    req(16'h2000, 2, 0, 0, 0, 1, 0);
    req(16'h200C, 2, 0, 0, 0, 2, 0);
    chk("R2 same line merges", cap_merged, 1);
    chk("R2 merge slot", cap_slot, 0);
    req(16'h2004, 3, 0, 0, 0, 1, 0);
    chk("R2 asid differs no merge", cap_merged, 0);
    chk("R2 asid differs slot", cap_slot, 1);
    req(16'h2010, 2, 0, 0, 0, 1, 0);
    chk("R2 line differs slot", cap_slot, 2);
  endtask

  task automatic t_noalloc();
    reset_dut();
    req(16'h3000, 0, 0, 0, 1, 1, 0);
    chk("R3 noalloc set", iss_noalloc, 1);
    req(16'h3004, 0, 0, 0, 0, 1, 0);
    chk("R3 noalloc cleared", iss_noalloc, 0);
  endtask

  task automatic t_tgt_cap();
    reset_dut();
    req(16'h4000, 0, 0, 0, 0, 1, 0);
    req(16'h5000, 0, 0, 0, 0, 1, 0);
    for (int k = 0; k < 3; k++) req(16'h5004, 0, 0, 0, 0, 2, 0);
    chk("R4 blk_tgt raised", blk_tgt, 1);
    chk("R4 ready low", req_ready, 0);
    chk("R4 capped entry first", iss_slot, 1);
    req(16'h6000, 0, 0, 0, 0, 1, 0);
    take();
    chk("R4 older next", iss_slot, 0);
    take();
    chk("R4 blocked req ignored", iss_valid, 0);
    fill(1, 0);
    chk("R9 fill clears blk_tgt", blk_tgt, 0);
    chk("R9 ready back", req_ready, 1);
  endtask

  task automatic t_full();
    reset_dut();
    for (int k = 0; k < 4; k++) req(16'h0100 * (k + 1), 0, 0, 0, 0, 1, 0);
    chk("R7 full raised", blk_full, 1);
    chk("R7 ready low", req_ready, 0);
    req(16'h0900, 0, 0, 0, 0, 1, 0);
    for (int k = 0; k < 4; k++) take();
    chk("R7 refused req not stored", iss_valid, 0);
    fill(2, 0);
    chk("R7 full cleared", blk_full, 0);
    req(16'h0A00, 0, 0, 0, 0, 1, 0);
    chk("R7 freed slot reused", cap_slot, 2);
  endtask

  task automatic t_repend();
    reset_dut();
    req(16'h7000, 0, 0, 0, 0, 1, 0);
    req(16'h7004, 0, 0, 0, 0, 3, 0);
    req(16'h8000, 0, 0, 0, 0, 1, 0);
    take();
    fill(0, 1);
    chk("R6 older stamp wins", iss_slot, 1);
    take();
    chk("R8 repend slot", iss_slot, 0);
    chk("R8 next target cmd", iss_cmd, 3);
    chk("R8 fresh stamp", iss_order, 2);
    take();
    fill(0, 1);
    chk("R8 last target frees", iss_valid, 0);
    req(16'h9000, 0, 0, 0, 0, 1, 0);
    chk("R8 freed slot reused", cap_slot, 0);
    chk("R6 stamp after repend", iss_order, 3);
  endtask

  task automatic t_squash();
    reset_dut();
    req(16'h9000, 0, 1, 0, 0, 1, 0);
    req(16'h9008, 0, 2, 0, 0, 1, 0);
    req(16'hA000, 0, 1, 0, 0, 1, 0);
    req(16'hB000, 0, 2, 0, 0, 1, 0);
    chk("R11 multi set", iss_multi, 1);
    squash(1);
    chk("R11 shared entry kept", iss_slot, 0);
    take();
    chk("R10 thread entry removed", iss_slot, 2);
    take();
    chk("R10 nothing left", iss_valid, 0);
    reset_dut();
    req(16'hC000, 0, 3, 0, 0, 1, 0);
    for (int k = 0; k < 3; k++) req(16'hC004, 0, 3, 0, 0, 1, 0);
    chk("R10 cap before squash", blk_tgt, 1);
    squash(3);
    chk("R10 squash clears blk_tgt", blk_tgt, 0);
    chk("R10 entry freed", iss_valid, 0);
  endtask

  initial begin
    t_reset();
    t_addr_size();
    t_merge();
    t_noalloc();
    t_tgt_cap();
    t_full();
    t_repend();
    t_squash();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule